// File: doc/BRIEF.md
# Systolic Bit-Serial Multiply-Add Array

This block computes `r = x*y + s` for three unsigned `N`-bit operands and returns the `2N`-bit result on one wire, least significant bit first. It is a linear chain of `N` identical cells. Each cell owns one bit of `x`, a full adder and a carry that stays inside the cell. Partial sums step one cell forward per clock. Bits of `y` step one cell forward every two clocks. Because cell `i` first needs its `x` bit `i` cycles after the start, `x` can arrive on a serial wire. Each cell takes its bit from that wire at the moment the bit first passes it.

An operation begins with a one-cycle `start` strobe, which marks cycle 0. In cycles 0 to `N-1`, bit `k` of each operand sits on `x_in`, `y_in` and `s_in` during cycle `k`. The block treats the upper halves of `y` and `s` as zero on its own. Any value on the serial inputs outside that window is ignored. The result appears on `r_out` from cycle `N` to `3N-1`, and `out_valid` marks those cycles. A new `start` may follow every `2N` cycles. The operands of the next product then enter while the upper half of the current result is still leaving, so the block delivers one product every `2N` cycles.

Top module: `bsm_array`

## Requirements
- R1: While `rst_n` is low and right after it is released, `out_valid` reads 0 and `r_out` reads 0.
- R2: With `start` high in cycle 0 and operand bit `k` presented in cycle `k` (k = 0..N-1), `r_out` in cycle `N+j` equals bit `j` of `x*y + s` for j = 0..2N-1.
- R3: `out_valid` is high in exactly cycles `N` to `3N-1` after each `start` and low in every other cycle.
- R4: `x` enters LSB first on `x_in`; a value on `x_in` in any cycle outside cycles 0..N-1 of an operation has no effect on any result.
- R5: `y_in` and `s_in` are only used in cycles 0..N-1 of an operation; bits `N..2N-1` of `y` and `s` are taken as 0 whatever the pins carry.
- R6: With `start` repeated every `2N` cycles, `out_valid` stays high without a gap and every result is correct; no carry or `y` bit of one operation leaks into the next.
- R7: All-ones operands (x = y = s = 2^N-1) give 2^(2N) - 2^N, and all-zero operands give 0.
- R8: Whenever `out_valid` is low, `r_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| start | input | 1 | Marks cycle 0 of an operation |
| x_in | input | 1 | Serial multiplicand, LSB first, cycles 0..N-1 |
| y_in | input | 1 | Serial multiplier, LSB first, cycles 0..N-1 |
| s_in | input | 1 | Serial addend, LSB first, cycles 0..N-1 |
| r_out | output | 1 | Serial result, LSB first, cycles N..3N-1 |
| out_valid | output | 1 | High while `r_out` carries a result bit |

## Verification
The bench builds the block with its default `N = 16`, so each result is 32 bits wide and the expected value fits a 64-bit bench variable. At this width, runs of 16 isolated cells plus a 32-cycle output window make it possible to try all-ones operands, where every carry chain ripples through the full array. It also allows back-to-back trains, where the last carry of one product sits right next to the first cycle of the next in every cell. Garbage is driven on all three serial inputs outside the operand window to show that those cycles are ignored.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  // Data passed from one cell to the next: partial sum bit and delayed y bit.
  typedef struct packed {
    logic sum;
    logic yb;
  } bsm_link_t;
endpackage

// File: rtl/bsm_cell.sv
module bsm_cell
  import bsm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lead,    // this cell's first cycle of an operation
  input  logic      x_ser,
  input  bsm_link_t link_i,
  output bsm_link_t link_o
);
  logic x_q, c_q, s_q, y1_q, y2_q;
  logic x_eff, c_in, pp, s_d, c_d;

  // Next-state logic: full adder on partial sum, partial product and own carry.
  always_comb begin
    x_eff = lead ? x_ser : x_q;
    c_in  = lead ? 1'b0 : c_q;
    pp    = x_eff & link_i.yb;
    s_d   = link_i.sum ^ pp ^ c_in;
    c_d   = (link_i.sum & pp) | (link_i.sum & c_in) | (pp & c_in);
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= 1'b0;
      c_q  <= 1'b0;
      s_q  <= 1'b0;
      y1_q <= 1'b0;
      y2_q <= 1'b0;
    end else begin
      if (lead) begin
        x_q <= x_ser;
      end
      c_q  <= c_d;
      s_q  <= s_d;
      y1_q <= link_i.yb;
      y2_q <= y1_q;
    end
  end

  assign link_o = '{sum: s_q, yb: y2_q};

  // The previous operation must have drained its carry by this cell's first cycle.
  assert_carry_drained_R6: assert property (
    @(posedge clk) disable iff (!rst_n) lead |-> !c_q);
endmodule

// File: rtl/bsm_sched.sv
module bsm_sched #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic [N-1:0] lead,
  output logic         accept,
  output logic         out_valid
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int OW = $clog2(2 * N);
  localparam logic [IW-1:0] IN_LOAD  = IW'(N - 1);
  localparam logic [OW-1:0] OUT_LOAD = OW'(2 * N - 1);

  logic          tail_q;
  logic [IW-1:0] in_cnt_q, in_cnt_d;
  logic [OW-1:0] out_cnt_q, out_cnt_d;

  assign lead[0] = start;

  // Start token moves one cell per cycle.
  generate
    if (N > 1) begin : g_chain
      logic [N-1:1] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= lead[N-2:0];
      end
      assign lead[N-1:1] = chain_q;
    end
  endgenerate

  always_comb begin
    if (start)                in_cnt_d = IN_LOAD;
    else if (in_cnt_q != '0)  in_cnt_d = in_cnt_q - 1'b1;
    else                      in_cnt_d = in_cnt_q;

    if (tail_q)               out_cnt_d = OUT_LOAD;
    else if (out_cnt_q != '0) out_cnt_d = out_cnt_q - 1'b1;
    else                      out_cnt_d = out_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q    <= 1'b0;
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
    end else begin
      tail_q    <= lead[N-1];
      in_cnt_q  <= in_cnt_d;
      out_cnt_q <= out_cnt_d;
    end
  end

  assign accept    = start | (in_cnt_q != '0);
  assign out_valid = tail_q | (out_cnt_q != '0);

  assert_accept_opens_R5: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(accept) |-> start);

  assert_valid_holds_R3: assert property (
    @(posedge clk) disable iff (!rst_n) tail_q |=> out_valid);
endmodule

// File: rtl/bsm_array.sv
module bsm_array
  import bsm_pkg::*;
#(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic x_in,
  input  logic y_in,
  input  logic s_in,
  output logic r_out,
  output logic out_valid
);
  logic [N-1:0] lead;
  logic         accept;
  bsm_link_t    link [N+1];
  logic         unused_ytail;

  bsm_sched #(.N(N)) sched_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lead      (lead),
    .accept    (accept),
    .out_valid (out_valid)
  );

  // Operand window gate: upper halves of y and s enter as zero.
  assign link[0] = '{sum: s_in & accept, yb: y_in & accept};

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      bsm_cell cell_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lead   (lead[i]),
        .x_ser  (x_in),
        .link_i (link[i]),
        .link_o (link[i+1])
      );
    end
  endgenerate

  assign r_out        = link[N].sum;
  assign unused_ytail = link[N].yb;

  assert_idle_quiet_R8: assert property (
    @(posedge clk) disable iff (!rst_n) !out_valid |-> !r_out);
endmodule

// File: tb/bsm_array_tb_top.sv
`timescale 1ns/1ps
module bsm_array_tb_top;
  localparam int N      = 16;
  localparam int MAXOPS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, x_in = 1'b0, y_in = 1'b0, s_in = 1'b0;
  logic r_out, out_valid;

  always #10 clk = ~clk;

  bsm_array #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
    .y_in(y_in), .s_in(s_in), .r_out(r_out), .out_valid(out_valid)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nops   = 0;
  int           op_start [MAXOPS];
  longint unsigned op_res [MAXOPS];
  longint unsigned op_got [MAXOPS];
  string        op_tag   [MAXOPS];

  localparam longint unsigned MASK = (64'd1 << N) - 64'd1;

  function automatic longint unsigned model(longint unsigned a, longint unsigned b,
                                            longint unsigned c);
    return (a & MASK) * (b & MASK) + (c & MASK);
  endfunction

  task automatic check(bit ok, string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic sample();
    logic ev;
    ev = 1'b0;
    for (int o = 0; o < nops; o++) begin
      int d;
      d = cyc - op_start[o];
      if (d >= N && d < 3 * N) begin
        ev = 1'b1;
        op_got[o][d-N] = r_out;
        if (d == 3 * N - 1)
          check(op_got[o] == op_res[o], op_tag[o], op_got[o], op_res[o]);
      end
    end
    check(out_valid == ev, "R3 out_valid window", 64'(out_valid), 64'(ev));
    if (!ev) check(r_out == 1'b0, "R8 idle output zero", 64'(r_out), 64'd0);
  endtask

  task automatic step(bit st, bit xb, bit yb, bit sb);
    @(negedge clk);
    sample();
    start = st; x_in = xb; y_in = yb; s_in = sb;
    cyc++;
  endtask

  task automatic run_op(longint unsigned a, longint unsigned b, longint unsigned c,
                        string tag);
    op_start[nops] = cyc;
    op_res[nops]   = model(a, b, c);
    op_got[nops]   = 64'd0;
    op_tag[nops]   = tag;
    nops++;
    for (int k = 0; k < 2 * N; k++) begin
      if (k < N) step(k == 0, a[k], b[k], c[k]);
      else       step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom));
    end
  endtask

  task automatic idle(int cnt);
    for (int k = 0; k < cnt; k++)
      step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  function automatic longint unsigned rnd();
    return {32'($urandom), 32'($urandom)} & MASK;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    check(r_out == 1'b0, "R1 r_out in reset", 64'(r_out), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    check(r_out == 1'b0, "R1 r_out after reset", 64'(r_out), 64'd0);

    // Directed corners, isolated.
    run_op(MASK, MASK, MASK, "R7 all-ones isolated");
    idle(3 * N);
    run_op(64'd0, 64'd0, 64'd0, "R7 all-zero isolated");
    idle(N + 3);
    run_op(64'd1, MASK, 64'd0, "R2 x=1 y=max");
    idle(N);
    run_op(MASK, 64'd1, MASK, "R2 R4 y=1 s=max");
    idle(2 * N + 5);

    // Random isolated operations with garbage outside the operand window.
    for (int r = 0; r < 8; r++) begin
      run_op(rnd(), rnd(), rnd(), "R2 R4 R5 random isolated");
      idle(N + int'($urandom % (2 * N)));
    end

    // Back-to-back trains.
    for (int r = 0; r < 10; r++)
      run_op(rnd(), rnd(), rnd(), "R6 back-to-back random");
    run_op(MASK, MASK, MASK, "R6 R7 back-to-back all-ones");
    run_op(MASK, MASK, MASK, "R6 R7 back-to-back all-ones again");
    run_op(64'd0, 64'd0, 64'd0, "R6 zero after all-ones");
    run_op(MASK, 64'd0, MASK, "R5 R6 y=0 s=max");
    idle(3 * N + 4);

    summary();
    $finish;
  end
endmodule